// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic and logic datapath of a small 8-bit microcontroller core. Each request carries an operation code, the two 8-bit accumulators A and B, the two 16-bit index registers X and Y, an already fetched memory operand of up to 16 bits, and the current condition code register. One clock later the block presents the new value of the destination register and the new condition code register. Instruction fetch, address generation and bus timing belong to other parts of the core.

The supported work covers 8-bit adds (accumulator plus accumulator, accumulator plus memory, with or without carry in), a 16-bit add onto the double accumulator D (A in the high byte, B in the low byte), adding B zero-extended to X or Y, AND of an accumulator with memory, and arithmetic shifts left and right on A, B, D (left only) and an 8-bit memory operand. Every operation has its own rule for which flags it writes; the rest of the condition code register passes through untouched.

Top module: `acc_alu`

## Requirements
- R1: After reset, res_o, ccr_o and valid_o are all zero. A request with valid_i high is answered in the next cycle with valid_o high and new res_o and ccr_o; in a cycle after valid_i was low, valid_o is low and res_o and ccr_o keep their previous values.
- R2: Operation codes on op_i: 0 A+B, 1 X+B, 2 Y+B, 3 A+M, 4 B+M, 5 A+M+C, 6 B+M+C, 7 D+M16, 8 A AND M, 9 B AND M, 10 shift A left, 11 shift B left, 12 shift D left, 13 shift M left, 14 shift A right, 15 shift B right, 16 shift M right. 8-bit results appear on res_o[7:0] with res_o[15:8] zero; M means mem_i[7:0] for 8-bit operations.
- R3: The 8-bit adds (codes 0, 3 to 6) write H as the carry out of bit 3, N as result bit 7, Z when the 8-bit result is zero, V on signed overflow and C as the carry out of bit 7; codes 5 and 6 add the incoming C.
- R4: Code 7 adds the full mem_i to D = {A, B}, returns the 16-bit sum, writes N (bit 15), Z, V and C from the 16-bit sum and keeps H.
- R5: Codes 1 and 2 add B zero-extended to 16 bits to X or Y, return the 16-bit sum modulo 2^16 and leave every flag unchanged.
- R6: Codes 8 and 9 write N and Z from the 8-bit result, clear V, and keep C and H.
- R7: Left shifts (codes 10 to 13) insert 0 at bit 0 and move the old top bit (bit 7, or bit 15 for D) into C; N is the result top bit, Z is set only when the whole result is zero, V = N XOR C; H is kept.
- R8: Right shifts (codes 14 to 16) move bit 0 into C and keep bit 7 in place; N, Z and V follow the R7 rules; H is kept.
- R9: The condition code layout is S bit 7, X bit 6, H bit 5, I bit 4, N bit 3, Z bit 2, V bit 1, C bit 0; no operation changes S, X or I.
- R10: Codes 17 to 31 return res_o = 0 and ccr_o equal to ccr_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 5 | Operation code (see R2) |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| x_i | input | 16 | Index register X |
| y_i | input | 16 | Index register Y |
| mem_i | input | 16 | Fetched memory operand |
| ccr_i | input | 8 | Current condition code register |
| valid_o | output | 1 | Result present |
| res_o | output | 16 | Destination register value |
| ccr_o | output | 8 | New condition code register |

## Verification
The bench aims at the flag boundaries: 0x7F plus 1 for signed overflow with half carry, 0xFF plus 1 for a zero result with carry, carry-in on the nibble edge, and 0x7FFF plus 1 on D; a design that took H from the wrong bit, dropped the carry in or wrote H on the 16-bit add would show a wrong ccr_o there. It adds B values with bit 7 set to X and Y, which catches sign extension, and runs shifts whose low byte is zero while the high byte is not, which catches a Z flag taken from only 8 bits, while inputs with S, X, I, H and C set expose any operation that writes a flag it should keep. Random operations, including undefined codes and idle cycles, are compared against a behavioural model every cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD_AB  = 5'd0,
    OP_IDX_X   = 5'd1,
    OP_IDX_Y   = 5'd2,
    OP_ADD_AM  = 5'd3,
    OP_ADD_BM  = 5'd4,
    OP_ADC_AM  = 5'd5,
    OP_ADC_BM  = 5'd6,
    OP_ADD_DM  = 5'd7,
    OP_AND_AM  = 5'd8,
    OP_AND_BM  = 5'd9,
    OP_SHL_A   = 5'd10,
    OP_SHL_B   = 5'd11,
    OP_SHL_D   = 5'd12,
    OP_SHL_M   = 5'd13,
    OP_SHR_A   = 5'd14,
    OP_SHR_B   = 5'd15,
    OP_SHR_M   = 5'd16
  } alu_op_e;

  // condition code bit positions
  localparam int CC_C = 0;
  localparam int CC_V = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;
  localparam int CC_I = 4;
  localparam int CC_H = 5;
  localparam int CC_X = 6;
  localparam int CC_S = 7;

endpackage

// File: rtl/acc_add.sv
module acc_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] full;

  always_comb begin
    full = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
    ovf  = (opa[W-1] == opb[W-1]) && (full[W-1] != opa[W-1]);
  end
endmodule

// File: rtl/acc_shift.sv
module acc_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         left,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    if (left) begin
      res  = {val[W-2:0], 1'b0};
      cout = val[W-1];
    end else begin
      res  = {val[W-1], val[W-1:1]};
      cout = val[0];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [4:0]      op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [2*DW-1:0] x_i,
  input  logic [2*DW-1:0] y_i,
  input  logic [2*DW-1:0] mem_i,
  input  logic [7:0]      ccr_i,
  output logic            valid_o,
  output logic [2*DW-1:0] res_o,
  output logic [7:0]      ccr_o
);
  localparam int WW  = 2 * DW;
  localparam int HB  = DW / 2;   // first bit above the low nibble

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [WW-1:0] d_val;
  logic [DW-1:0] m8;
  assign d_val = {a_i, b_i};
  assign m8    = mem_i[DW-1:0];

  // 8-bit adder
  logic [DW-1:0] add8_p, add8_q, add8_s;
  logic          add8_ci, add8_co, add8_v, add8_h;

  always_comb begin
    add8_p  = (op == OP_ADD_BM || op == OP_ADC_BM) ? b_i : a_i;
    add8_q  = (op == OP_ADD_AB) ? b_i : m8;
    add8_ci = (op == OP_ADC_AM || op == OP_ADC_BM) ? ccr_i[CC_C] : 1'b0;
  end

  acc_add #(.W(DW)) u_add8 (
    .opa(add8_p), .opb(add8_q), .cin(add8_ci),
    .sum(add8_s), .cout(add8_co), .ovf(add8_v)
  );

  // carry into bit HB recovered from the operand and sum bits
  assign add8_h = add8_p[HB] ^ add8_q[HB] ^ add8_s[HB];

  // 16-bit adder shared by the index and double-accumulator adds
  logic [WW-1:0] add16_p, add16_q, add16_s;
  logic          add16_co, add16_v;

  always_comb begin
    case (op)
      OP_IDX_X: begin add16_p = x_i; add16_q = {{DW{1'b0}}, b_i}; end
      OP_IDX_Y: begin add16_p = y_i; add16_q = {{DW{1'b0}}, b_i}; end
      default:  begin add16_p = d_val; add16_q = mem_i; end
    endcase
  end

  acc_add #(.W(WW)) u_add16 (
    .opa(add16_p), .opb(add16_q), .cin(1'b0),
    .sum(add16_s), .cout(add16_co), .ovf(add16_v)
  );

  // 8-bit shifter
  logic [DW-1:0] sh8_in, sh8_out;
  logic          sh8_left, sh8_co;

  always_comb begin
    case (op)
      OP_SHL_A, OP_SHR_A: sh8_in = a_i;
      OP_SHL_B, OP_SHR_B: sh8_in = b_i;
      default:            sh8_in = m8;
    endcase
    sh8_left = (op == OP_SHL_A) || (op == OP_SHL_B) || (op == OP_SHL_M);
  end

  acc_shift #(.W(DW)) u_sh8 (
    .val(sh8_in), .left(sh8_left), .res(sh8_out), .cout(sh8_co)
  );

  // 16-bit shifter, left only
  logic [WW-1:0] sh16_out;
  logic          sh16_co;

  acc_shift #(.W(WW)) u_sh16 (
    .val(d_val), .left(1'b1), .res(sh16_out), .cout(sh16_co)
  );

  logic [DW-1:0] and8;
  assign and8 = ((op == OP_AND_AM) ? a_i : b_i) & m8;

  // result and flag selection
  logic [WW-1:0] nxt_res;
  logic [7:0]    nxt_ccr;

  always_comb begin
    nxt_res = '0;
    nxt_ccr = ccr_i;
    case (op)
      OP_ADD_AB, OP_ADD_AM, OP_ADD_BM, OP_ADC_AM, OP_ADC_BM: begin
        nxt_res         = {{DW{1'b0}}, add8_s};
        nxt_ccr[CC_H]   = add8_h;
        nxt_ccr[CC_N]   = add8_s[DW-1];
        nxt_ccr[CC_Z]   = (add8_s == '0);
        nxt_ccr[CC_V]   = add8_v;
        nxt_ccr[CC_C]   = add8_co;
      end
      OP_IDX_X, OP_IDX_Y: begin
        nxt_res = add16_s;
      end
      OP_ADD_DM: begin
        nxt_res         = add16_s;
        nxt_ccr[CC_N]   = add16_s[WW-1];
        nxt_ccr[CC_Z]   = (add16_s == '0);
        nxt_ccr[CC_V]   = add16_v;
        nxt_ccr[CC_C]   = add16_co;
      end
      OP_AND_AM, OP_AND_BM: begin
        nxt_res         = {{DW{1'b0}}, and8};
        nxt_ccr[CC_N]   = and8[DW-1];
        nxt_ccr[CC_Z]   = (and8 == '0);
        nxt_ccr[CC_V]   = 1'b0;
      end
      OP_SHL_D: begin
        nxt_res         = sh16_out;
        nxt_ccr[CC_N]   = sh16_out[WW-1];
        nxt_ccr[CC_Z]   = (sh16_out == '0);
        nxt_ccr[CC_V]   = sh16_out[WW-1] ^ sh16_co;
        nxt_ccr[CC_C]   = sh16_co;
      end
      OP_SHL_A, OP_SHL_B, OP_SHL_M, OP_SHR_A, OP_SHR_B, OP_SHR_M: begin
        nxt_res         = {{DW{1'b0}}, sh8_out};
        nxt_ccr[CC_N]   = sh8_out[DW-1];
        nxt_ccr[CC_Z]   = (sh8_out == '0);
        nxt_ccr[CC_V]   = sh8_out[DW-1] ^ sh8_co;
        nxt_ccr[CC_C]   = sh8_co;
      end
      default: ;
    endcase
  end

  // output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      ccr_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= nxt_res;
        ccr_o <= nxt_ccr;
      end
    end
  end

  // assertions
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!valid_o && $stable(res_o) && $stable(ccr_o)));

  p_index_noflag_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 5'd1 || op_i == 5'd2)) |=> ccr_o == $past(ccr_i));

  p_addd_keep_h_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 5'd7) |=> ccr_o[CC_H] == $past(ccr_i[CC_H]));

  p_and_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 5'd8 || op_i == 5'd9)) |=>
      (!ccr_o[CC_V] && ccr_o[CC_C] == $past(ccr_i[CC_C])));

  p_sxi_keep_r9: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ((ccr_o & 8'hD0) == ($past(ccr_i) & 8'hD0)));

  p_shift_v_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i >= 5'd10 && op_i <= 5'd16) |=>
      ccr_o[CC_V] == (ccr_o[CC_N] ^ ccr_o[CC_C]));

  p_undef_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i > 5'd16) |=> (res_o == '0 && ccr_o == $past(ccr_i)));

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [4:0]  op_i;
  logic [7:0]  a_i, b_i, ccr_i;
  logic [15:0] x_i, y_i, mem_i;
  logic        valid_o;
  logic [15:0] res_o;
  logic [7:0]  ccr_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .x_i(x_i), .y_i(y_i), .mem_i(mem_i),
    .ccr_i(ccr_i), .valid_o(valid_o), .res_o(res_o), .ccr_o(ccr_o)
  );

  // behavioural reference from the requirements
  function automatic void ref_model(input int op, input int a, input int b,
      input int x, input int y, input int m, input int cc,
      output int r, output int nc);
    int d, p, q, ci, s, n, z, v, c, h;
    d = a * 256 + b;
    case (op)
      0, 3, 4, 5, 6: begin
        p  = (op == 4 || op == 6) ? b : a;
        q  = (op == 0) ? b : (m & 255);
        ci = (op == 5 || op == 6) ? (cc & 1) : 0;
        s  = p + q + ci;
        r  = s & 255;
        c  = (s > 255) ? 1 : 0;
        h  = (((p & 15) + (q & 15) + ci) > 15) ? 1 : 0;
        n  = (r >= 128) ? 1 : 0;
        z  = (r == 0) ? 1 : 0;
        v  = ((((p ^ r) & (q ^ r)) & 128) != 0) ? 1 : 0;
        nc = (cc & 'hD0) | (h << 5) | (n << 3) | (z << 2) | (v << 1) | c;
      end
      1: begin r = (x + b) % 65536; nc = cc; end
      2: begin r = (y + b) % 65536; nc = cc; end
      7: begin
        s  = d + m;
        r  = s % 65536;
        c  = (s > 65535) ? 1 : 0;
        n  = (r >= 32768) ? 1 : 0;
        z  = (r == 0) ? 1 : 0;
        v  = ((((d ^ r) & (m ^ r)) & 32768) != 0) ? 1 : 0;
        nc = (cc & 'hF0) | (n << 3) | (z << 2) | (v << 1) | c;
      end
      8, 9: begin
        r  = ((op == 8) ? a : b) & m & 255;
        n  = (r >= 128) ? 1 : 0;
        z  = (r == 0) ? 1 : 0;
        nc = (cc & 'hF1) | (n << 3) | (z << 2);
      end
      10, 11, 13: begin
        p  = (op == 10) ? a : (op == 11) ? b : (m & 255);
        r  = (p * 2) % 256;
        c  = p / 128;
        n  = r / 128;
        z  = (r == 0) ? 1 : 0;
        v  = n ^ c;
        nc = (cc & 'hF0) | (n << 3) | (z << 2) | (v << 1) | c;
      end
      12: begin
        r  = (d * 2) % 65536;
        c  = d / 32768;
        n  = r / 32768;
        z  = (r == 0) ? 1 : 0;
        v  = n ^ c;
        nc = (cc & 'hF0) | (n << 3) | (z << 2) | (v << 1) | c;
      end
      14, 15, 16: begin
        p  = (op == 14) ? a : (op == 15) ? b : (m & 255);
        r  = (p / 2) + (p & 128);
        c  = p % 2;
        n  = r / 128;
        z  = (r == 0) ? 1 : 0;
        v  = n ^ c;
        nc = (cc & 'hF0) | (n << 3) | (z << 2) | (v << 1) | c;
      end
      default: begin r = 0; nc = cc; end
    endcase
  endfunction

  function automatic string tag_of(input int op, input bit flags);
    if (op == 0 || (op >= 3 && op <= 6)) return flags ? "R3" : "R2";
    if (op == 1 || op == 2) return "R5";
    if (op == 7) return "R4";
    if (op == 8 || op == 9) return "R6";
    if (op >= 10 && op <= 13) return "R7";
    if (op >= 14 && op <= 16) return "R8";
    return "R10";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  int exp_res = 0;
  int exp_ccr = 0;

  // one request, checked at the next falling edge
  task automatic apply(input int op, input int a, input int b, input int x,
                       input int y, input int m, input int cc);
    int r, nc;
    valid_i = 1'b1;
    op_i    = 5'(op);
    a_i     = 8'(a);
    b_i     = 8'(b);
    x_i     = 16'(x);
    y_i     = 16'(y);
    mem_i   = 16'(m);
    ccr_i   = 8'(cc);
    ref_model(op, a, b, x, y, m, cc, r, nc);
    exp_res = r;
    exp_ccr = nc;
    @(negedge clk);
    check(valid_o == 1'b1, "R1", "valid_o", int'(valid_o), 1);
    check(int'(res_o) == exp_res, tag_of(op, 1'b0), "res_o", int'(res_o), exp_res);
    check(int'(ccr_o) == exp_ccr, tag_of(op, 1'b1), "ccr_o", int'(ccr_o), exp_ccr);
    check((ccr_o & 8'hD0) == (8'(cc) & 8'hD0), "R9", "S/X/I bits",
          int'(ccr_o & 8'hD0), cc & 'hD0);
  endtask

  task automatic idle();
    valid_i = 1'b0;
    op_i    = 5'd0;
    ccr_i   = ~ccr_i;
    a_i     = ~a_i;
    @(negedge clk);
    check(valid_o == 1'b0, "R1", "idle valid_o", int'(valid_o), 0);
    check(int'(res_o) == exp_res, "R1", "idle res_o hold", int'(res_o), exp_res);
    check(int'(ccr_o) == exp_ccr, "R1", "idle ccr_o hold", int'(ccr_o), exp_ccr);
  endtask

  initial begin
    rst = 1'b1; valid_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
    x_i = '0; y_i = '0; mem_i = '0; ccr_i = '0;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && res_o == 16'h0 && ccr_o == 8'h0, "R1",
          "reset state", int'({valid_o, ccr_o, res_o}), 0);
    rst = 1'b0;

    // R3: signed overflow with half carry, zero with carry, carry in at nibble edge
    apply(0, 'h7F, 'h01, 0, 0, 0, 'h00);
    apply(3, 'hFF, 0, 0, 0, 'h0001, 'h00);
    apply(5, 'h0F, 0, 0, 0, 'h0000, 'hD1);
    apply(6, 'h80, 'h80, 0, 0, 'h0080, 'h01);
    apply(4, 'h00, 'h10, 0, 0, 'h0020, 'hFF);
    idle();
    // R4: D overflow keeps H, D wrap to zero
    apply(7, 'h7F, 'hFF, 0, 0, 'h0001, 'h20);
    apply(7, 'hFF, 'hFF, 0, 0, 'h0001, 'h00);
    // R5: zero extension, wrap, flags untouched
    apply(1, 0, 'h01, 'hFFFF, 0, 0, 'hFF);
    apply(2, 0, 'h80, 0, 'h1000, 0, 'h2A);
    // R6: V cleared, C kept
    apply(8, 'hF0, 0, 0, 0, 'h0080, 'h03);
    apply(9, 0, 'h0F, 0, 0, 'hFFF0, 'h22);
    // R7: shift left to zero, D high bit, D low byte zero but not whole
    apply(10, 'h80, 0, 0, 0, 0, 'h20);
    apply(12, 'h40, 'h00, 0, 0, 0, 'h00);
    apply(12, 'h00, 'h80, 0, 0, 0, 'h0F);
    apply(13, 0, 0, 0, 0, 'hFF41, 'h00);
    // R8: sign kept, bit 0 to C
    apply(15, 0, 'h81, 0, 0, 0, 'h00);
    apply(16, 0, 0, 0, 0, 'h0001, 'h28);
    apply(14, 'h7E, 0, 0, 0, 0, 'hFF);
    // R10: undefined codes
    apply(17, 'h12, 'h34, 'h5678, 'h9ABC, 'hDEF0, 'hA5);
    apply(31, 'hFF, 'hFF, 'hFFFF, 'hFFFF, 'hFFFF, 'h5A);
    idle();

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else apply(int'($urandom_range(0, 20)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 255)));
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule